// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks through the column addresses of one SDRAM burst. A memory controller loads a start column together with the burst settings: length selection and wrap ordering. It then pulses an advance strobe once per data beat. The block presents the current column on every cycle. For fixed-length bursts it also flags the final beat, so the controller knows when the burst is complete.

Two wrap orders are supported. Sequential order counts upward inside an aligned window of the burst length. Interleaved order flips the window bits of the start column by a beat count. A full-page setting ignores the window. It counts through the whole column space and wraps at the top, and it never ends on its own: only a terminate pulse or a new load ends it. A new start column may be loaded on any cycle, including during a running burst, and the new burst starts at once.

Top module: `burst_col_gen`

## Requirements
- R1: `lenSel` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. `lastBeat` is high, together with `active`, exactly while the burst shows its final beat, which is after N-1 steps for an N-beat burst.
- R2: In sequential order (`wrapIlv`=0) with N beats, after k steps the low log2(N) bits of `colAddr` equal (start + k) mod N. The remaining upper bits equal those of the start column.
- R3: In interleaved order (`wrapIlv`=1) with N beats, after k steps the low log2(N) bits of `colAddr` equal the start bits XOR k. The upper bits equal those of the start column.
- R4: Setting `lenSel[2]`=1 selects full page. After k steps `colAddr` = (start + k) mod 2^COL_W, whatever `wrapIlv` is. `lastBeat` never rises, and the burst runs until `stop` or a new load.
- R5: A clock edge with `loadEn`=1 makes `colAddr` equal `startCol` and `active` equal 1 from the next cycle. This holds on every cycle, and a load takes priority over `advance` and `stop`.
- R6: A clock edge with `stop`=1 and no load clears `active`. `colAddr` keeps the address it showed.
- R7: An `advance` on the final beat of a fixed-length burst clears `active`, and `colAddr` keeps the final address.
- R8: Without a load, `colAddr` does not change on an edge where `advance` is low or `active` is low. `advance` and `stop` while idle have no effect.
- R9: After reset, `active`, `lastBeat` and `colAddr` are all 0.
- R10: The length and order are captured at load time. Changing `lenSel` or `wrapIlv` during a burst does not change its addresses or its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Start a new burst at `startCol` |
| startCol | input | COL_W | Start column for a load |
| lenSel | input | 3 | Burst length: 0..3 give 2^lenSel beats, bit 2 set gives full page |
| wrapIlv | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| advance | input | 1 | Step to the next beat |
| stop | input | 1 | Terminate the running burst |
| colAddr | output | COL_W | Current column address |
| active | output | 1 | A burst is in progress |
| lastBeat | output | 1 | Current beat is the last of a fixed-length burst |

## Verification
A wrong beat count or a corrupted captured start column shows up on `colAddr` in the cycle after the faulty edge. The same holds when an upper column bit is disturbed, so each beat of a burst is compared against an address computed separately. A down-counter that is off by one moves `lastBeat` by a cycle and changes the cycle in which `active` falls. Both are checked on every beat of every length. A full-page flag that is lost or taken from the live inputs shows up as a spurious `lastBeat`, or as a wrap confined to a window. A full-page burst run across the top column, and a burst whose settings change mid-run, expose either fault within a few beats.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic capture;   // take a new start column, clear the beat count
    logic step;      // move to the next beat
  } colStrobe_t;

  // Burst settings captured at load time.
  typedef struct packed {
    logic       fullPage;
    logic       ilv;
    logic [1:0] lenLog;
  } burstCfg_t;

  localparam int LEN_LOG_W = 2;
  localparam int MAX_LEN_LOG = (1 << LEN_LOG_W) - 1;

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic [2:0] lenSel,
  input  logic       wrapIlv,
  input  logic       advance,
  input  logic       stop,
  output colStrobe_t strobes,
  output burstCfg_t  cfg,
  output logic       active,
  output logic       lastBeat
);

  localparam int REM_W = MAX_LEN_LOG;

  logic [REM_W-1:0] beatsLeft;
  logic [REM_W-1:0] loadRemain;
  logic             finishing;

  always_comb begin
    loadRemain = '0;
    for (int b = 0; b < REM_W; b++) begin
      if (b < int'(lenSel[1:0])) loadRemain[b] = 1'b1;
    end
  end

  assign lastBeat  = active && !cfg.fullPage && (beatsLeft == '0);
  assign finishing = active && !loadEn && (stop || (advance && lastBeat));

  always_comb begin
    strobes.capture = loadEn;
    strobes.step    = !loadEn && active && advance && !lastBeat && !stop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      beatsLeft <= '0;
      cfg       <= '0;
    end else if (loadEn) begin
      active       <= 1'b1;
      beatsLeft    <= loadRemain;
      cfg.fullPage <= lenSel[2];
      cfg.ilv      <= wrapIlv && !lenSel[2];
      cfg.lenLog   <= lenSel[1:0];
    end else if (finishing) begin
      active <= 1'b0;
    end else if (strobes.step && !cfg.fullPage) begin
      beatsLeft <= beatsLeft - 1'b1;
    end
  end

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       strobes,
  input  burstCfg_t        cfg,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colAddr
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatCnt;
  logic [COL_W-1:0] sumCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol <= '0;
      beatCnt <= '0;
    end else if (strobes.capture) begin
      baseCol <= startCol;
      beatCnt <= '0;
    end else if (strobes.step) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  assign sumCol = baseCol + beatCnt;

  // Low bits of the sum depend only on low bits of the operands, so a
  // per-bit pick between sum, XOR and base gives the wrap inside the window.
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    logic inWindow;
    assign inWindow = cfg.fullPage || (i < int'(cfg.lenLog));
    assign colAddr[i] = !inWindow ? baseCol[i] :
                        cfg.ilv   ? (baseCol[i] ^ beatCnt[i]) : sumCol[i];
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenSel,
  input  logic             wrapIlv,
  input  logic             advance,
  input  logic             stop,
  output logic [COL_W-1:0] colAddr,
  output logic             active,
  output logic             lastBeat
);

  colStrobe_t strobeBus;
  burstCfg_t  cfgBus;

  burst_col_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadEn   (loadEn),
    .lenSel   (lenSel),
    .wrapIlv  (wrapIlv),
    .advance  (advance),
    .stop     (stop),
    .strobes  (strobeBus),
    .cfg      (cfgBus),
    .active   (active),
    .lastBeat (lastBeat)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobeBus),
    .cfg      (cfgBus),
    .startCol (startCol),
    .colAddr  (colAddr)
  );

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadEn,
  input logic [COL_W-1:0] startCol,
  input logic             advance,
  input logic             stop,
  input logic [COL_W-1:0] colAddr,
  input logic             active,
  input logic             lastBeat,
  input logic             fullPageCfg
);

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> active && (colAddr == $past(startCol))); // R5

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    stop && !loadEn |=> !active && $stable(colAddr)); // R6

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && advance && !loadEn |=> !active && $stable(colAddr)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !active && !loadEn |=> !active && $stable(colAddr)); // R8

  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !advance && !loadEn |=> $stable(colAddr)); // R8

  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rstN)
    fullPageCfg |-> !lastBeat); // R4

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> active); // R1

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    active && !fullPageCfg && !loadEn |=>
      colAddr[COL_W-1:3] == $past(colAddr[COL_W-1:3])); // R2

  always_comb begin
    if (!rstN) begin
      AST_RESET_IDLE: assert (!active && !lastBeat); // R9
    end
  end

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .loadEn      (loadEn),
  .startCol    (startCol),
  .advance     (advance),
  .stop        (stop),
  .colAddr     (colAddr),
  .active      (active),
  .lastBeat    (lastBeat),
  .fullPageCfg (cfgBus.fullPage)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             loadEn = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenSel = '0;
  logic             wrapIlv = 1'b0;
  logic             advance = 1'b0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] colAddr;
  logic             active;
  logic             lastBeat;

  int numChecks = 0;
  int numFails  = 0;

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .startCol(startCol),
    .lenSel(lenSel), .wrapIlv(wrapIlv), .advance(advance), .stop(stop),
    .colAddr(colAddr), .active(active), .lastBeat(lastBeat)
  );

  task automatic check(input string req, input int act, input int exp);
    numChecks++;
    if (act != exp) begin
      numFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Edge, then settle 5 ns into the high phase before sampling or driving.
  task automatic cyc();
    @(posedge clk);
    #5;
  endtask

  function automatic int expAddr(input int start, input int lenLog,
                                 input bit ilv, input bit full, input int k);
    int n;
    int low;
    n = 1 << lenLog;
    if (full) return (start + k) % PAGE;
    if (ilv) low = (start % n) ^ (k % n);
    else     low = ((start % n) + k) % n;
    return (start - (start % n)) + low;
  endfunction

  task automatic startBurst(input int start, input int sel, input bit ilv);
    startCol = COL_W'(start);
    lenSel   = 3'(sel);
    wrapIlv  = ilv;
    loadEn   = 1'b1;
    cyc();
    loadEn   = 1'b0;
  endtask

  // Fixed-length burst stepped every cycle to its end.
  task automatic runFixed(input string req, input int start, input int lenLog,
                          input bit ilv);
    int n;
    n = 1 << lenLog;
    startBurst(start, lenLog, ilv);
    advance = 1'b1;
    for (int k = 0; k < n; k++) begin
      check({req, " addr"}, colAddr, expAddr(start, lenLog, ilv, 1'b0, k));
      check("R1 lastBeat", lastBeat, (k == n - 1) ? 1 : 0);
      check("R1 active", active, 1);
      cyc();
    end
    advance = 1'b0;
    check("R7 active after end", active, 0);
    check("R7 addr held", colAddr, expAddr(start, lenLog, ilv, 1'b0, n - 1));
    check("R7 lastBeat after end", lastBeat, 0);
  endtask

  task automatic testReset();
    check("R9 active", active, 0);
    check("R9 lastBeat", lastBeat, 0);
    check("R9 colAddr", colAddr, 0);
  endtask

  task automatic testSequential();
    for (int l = 0; l < 4; l++) runFixed("R2 seq", 'h2D6, l, 1'b0);
    runFixed("R2 seq", 'h0FF, 3, 1'b0);
  endtask

  task automatic testInterleaved();
    for (int l = 0; l < 4; l++) runFixed("R3 ilv", 'h13B, l, 1'b1);
    runFixed("R3 ilv", 'h3F6, 2, 1'b1);
  endtask

  task automatic testFullPage();
    // wrapIlv=1 is set to show that it is ignored in full page.
    startBurst('h3FD, 4, 1'b1);
    advance = 1'b1;
    for (int k = 0; k < 12; k++) begin
      check("R4 full addr", colAddr, expAddr('h3FD, 0, 1'b0, 1'b1, k));
      check("R4 no lastBeat", lastBeat, 0);
      check("R4 active", active, 1);
      cyc();
    end
    advance = 1'b0;
    stop = 1'b1;
    cyc();
    stop = 1'b0;
    check("R6 stop ends full", active, 0);
    check("R6 stop holds addr", colAddr, expAddr('h3FD, 0, 1'b0, 1'b1, 12));
  endtask

  task automatic testStopAndIdle();
    startBurst('h105, 3, 1'b0);
    advance = 1'b1;
    cyc();
    cyc();
    advance = 1'b0;
    stop = 1'b1;
    cyc();
    stop = 1'b0;
    check("R6 stop mid burst", active, 0);
    check("R6 addr held", colAddr, 'h107);
    advance = 1'b1;
    cyc();
    cyc();
    advance = 1'b0;
    check("R8 idle advance addr", colAddr, 'h107);
    check("R8 idle advance active", active, 0);
    stop = 1'b1;
    cyc();
    stop = 1'b0;
    check("R8 idle stop addr", colAddr, 'h107);
  endtask

  task automatic testStall();
    startBurst('h042, 2, 1'b0);
    advance = 1'b1;
    cyc();
    advance = 1'b0;
    cyc();
    cyc();
    check("R8 stall addr", colAddr, 'h043);
    check("R8 stall active", active, 1);
  endtask

  task automatic testRestart();
    startBurst('h200, 3, 1'b0);
    advance = 1'b1;
    cyc();
    // Loads on consecutive cycles, with advance and stop also high.
    stop = 1'b1;
    loadEn = 1'b1;
    for (int j = 0; j < 3; j++) begin
      startCol = COL_W'('h050 + 'h111 * j);
      cyc();
      check("R5 restart addr", colAddr, 'h050 + 'h111 * j);
      check("R5 restart active", active, 1);
    end
    loadEn = 1'b0;
    stop = 1'b0;
    cyc();
    check("R5 steps after restart", colAddr, expAddr('h272, 3, 1'b0, 1'b0, 1));
    advance = 1'b0;
  endtask

  task automatic testCapture();
    startBurst('h0A1, 2, 1'b0);
    lenSel  = 3'b100;
    wrapIlv = 1'b1;
    advance = 1'b1;
    for (int k = 0; k < 4; k++) begin
      check("R10 addr", colAddr, expAddr('h0A1, 2, 1'b0, 1'b0, k));
      check("R10 lastBeat", lastBeat, (k == 3) ? 1 : 0);
      cyc();
    end
    advance = 1'b0;
    check("R10 ended", active, 0);
  endtask

  bit finished = 1'b0;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", numChecks, numFails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      numChecks++;
      numFails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    testReset();
    rstN = 1'b1;
    cyc();
    testReset();
    testSequential();
    testInterleaved();
    testFullPage();
    testStopAndIdle();
    testStall();
    testRestart();
    testCapture();
    finished = 1'b1;
    report();
  end

endmodule